// File: doc/BRIEF.md
# Frame Base Double-Buffer and Run Controller

This unit sits beside a display scan-out engine and owns three pieces of state: the address of the frame being scanned, a shadow holding the address of the frame to show next, and the run state of the transfer engine. Software may load the shadow at any moment. The shadow is copied into the scanned address only at a vertical-sync strobe, so a buffer flip never tears a frame. The memory fetch itself lives elsewhere. This unit hands it the current base and the run flag, and pulses a FIFO flush request on demand.

Software starts scan-out by setting the run bit together with the mode-enable bit. It can stop scan-out in two ways. A graceful stop drops the mode-enable bit: the engine keeps running until the pixel FIFO reports empty, and only then does the run bit fall. A forced stop clears the run bit directly and takes effect at once. The control register and the auxiliary register can each be reached at three addresses: a plain write, a set alias that ORs bits in, and a clear alias that removes them. The control register also holds a soft-reset bit and a clock-gate bit that freezes flips and drain completion.

Top module: `fbc_frame_base_ctrl`

## Requirements
- R1: After reset, cur_base is 0, run_active is 0 and fifo_clr is 0.
- R2: A plain write to offset 0x20 loads the shadow base at any time. cur_base takes the shadow value one cycle after a vsync strobe that is sampled while run is 1, clock-gate is 0 and soft-reset is 0. At any other time cur_base holds.
- R3: If the shadow is written several times between strobes, only the last value is promoted. If a shadow write falls in the same cycle as a strobe, the value written earlier is promoted and the new value waits for the following strobe.
- R4: The control register has its plain write at 0x00, its set alias at 0x04 and its clear alias at 0x08. Run is bit 0, mode-enable is bit 4, clock-gate is bit 30 and soft-reset is bit 31. Setting run together with mode-enable makes run_active 1 in the cycle after the write.
- R5: If mode-enable is 0 while run is 1, run stays 1 until fifo_empty is sampled high at a clock edge, and run_active is 0 after that edge.
- R6: Clearing bit 0 through the clear alias 0x08 drops run_active in the next cycle, whatever the FIFO state.
- R7: Writing 1 to bit 0 of the auxiliary register, through the plain write at 0x10 or the set alias at 0x14, while run is 0 gives a one-cycle fifo_clr pulse in the cycle after the write. The same write is ignored while running, and a write through the clear alias 0x18 never pulses.
- R8: While clock-gate is 1, vsync strobes promote nothing and a pending drain does not complete. The drain completes on the first edge after clock-gate is cleared.
- R9: While soft-reset is 1, run and mode-enable are forced to 0, and from the following cycle both the current and the shadow base are held at 0. Shadow writes are ignored until soft-reset is cleared.
- R10: A write to offset 0x30 has no effect on cur_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the write |
| reg_wdata | input | 32 | Write data |
| vsync | input | 1 | One-cycle frame-boundary strobe |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| cur_base | output | BASE_W | Base address of the frame being scanned |
| run_active | output | 1 | Transfer engine run state |
| fifo_clr | output | 1 | One-cycle request to flush the pixel FIFO |

## Verification
The shadow load and the flip can collide. A write to 0x20 and a vsync strobe are driven together on the same falling edge. The bench expects cur_base to take the value written before that edge, and only the next strobe may expose the new value. Graceful stop and clock-gate are also put in the same window. The bench checks that an empty FIFO does not end the drain while the gate is set, and that run falls exactly one edge after the gate is released.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int REG_W         = 32;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_BIT = 4;
    localparam int CTRL_GATE_BIT = 30;
    localparam int CTRL_SRST_BIT = 31;
    localparam int AUX_FCLR_BIT  = 0;
    localparam int CTRL_FIELDS   = 4;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_AUX  = 2'd2,
        TGT_NEXT = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic srst;
        logic gate;
        logic mode;
        logic run;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  fclr;
    } run_state_t;

    function automatic logic apply_op(wr_op_e op, logic old_bit, logic new_bit);
        case (op)
            OP_WRITE: apply_op = new_bit;
            OP_SET:   apply_op = old_bit | new_bit;
            OP_CLR:   apply_op = old_bit & ~new_bit;
            default:  apply_op = old_bit;
        endcase
    endfunction

endpackage

// File: rtl/fbc_reg_decode.sv
module fbc_reg_decode
    import fbc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] AUX_OFS  = 'h10,
    parameter logic [ADDR_W-1:0] NEXT_OFS = 'h20
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_tgt_e           tgt,
    output wr_op_e            op
);

    localparam logic [ADDR_W-1:0] GRP_MASK = {{(ADDR_W-4){1'b1}}, 4'h0};

    logic [ADDR_W-1:0] grp;
    logic [3:0]        sub;
    wr_op_e            alias_op;

    assign grp = addr & GRP_MASK;
    assign sub = addr[3:0];

    always_comb begin
        case (sub)
            4'h0:    alias_op = OP_WRITE;
            4'h4:    alias_op = OP_SET;
            4'h8:    alias_op = OP_CLR;
            default: alias_op = OP_NONE;
        endcase
    end

    always_comb begin
        tgt = TGT_NONE;
        op  = OP_NONE;
        if (wr) begin
            if (grp == CTRL_OFS && alias_op != OP_NONE) begin
                tgt = TGT_CTRL;
                op  = alias_op;
            end else if (grp == AUX_OFS && alias_op != OP_NONE) begin
                tgt = TGT_AUX;
                op  = alias_op;
            end else if (grp == NEXT_OFS && alias_op == OP_WRITE) begin
                tgt = TGT_NEXT;
                op  = OP_WRITE;
            end
        end
    end

endmodule

// File: rtl/fbc_run_ctrl.sv
module fbc_run_ctrl
    import fbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_tgt_e tgt,
    input  wr_op_e  op,
    input  ctrl_t   wr_ctrl,
    input  logic    wr_fclr,
    input  logic    fifo_empty,
    output ctrl_t   ctrl_q,
    output logic    fclr_q
);

    run_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.fclr = 1'b0;

        // register writes through the three aliases
        if (tgt == TGT_CTRL) begin
            for (int i = 0; i < CTRL_FIELDS; i++) begin
                state_d.ctrl[i] = apply_op(op, state_q.ctrl[i], wr_ctrl[i]);
            end
        end

        // soft reset overrides run and mode
        if (state_d.ctrl.srst) begin
            state_d.ctrl.run  = 1'b0;
            state_d.ctrl.mode = 1'b0;
        end

        // graceful stop: run falls once the FIFO has drained
        if (state_d.ctrl.run && !state_d.ctrl.mode && fifo_empty && !state_q.ctrl.gate) begin
            state_d.ctrl.run = 1'b0;
        end

        // flush request only honoured while stopped
        if (tgt == TGT_AUX && (op == OP_WRITE || op == OP_SET) && wr_fclr
            && !state_q.ctrl.run && !state_q.ctrl.srst) begin
            state_d.fclr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_q = state_q.ctrl;
    assign fclr_q = state_q.fclr;

endmodule

// File: rtl/fbc_base_shadow.sv
module fbc_base_shadow
    import fbc_pkg::*;
#(
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_tgt_e           tgt,
    input  logic [BASE_W-1:0] wr_base,
    input  logic              vsync,
    input  logic              run,
    input  logic              gate,
    input  logic              srst,
    output logic [BASE_W-1:0] cur_q,
    output logic [BASE_W-1:0] next_q
);

    typedef struct packed {
        logic [BASE_W-1:0] cur;
        logic [BASE_W-1:0] next;
    } base_state_t;

    base_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (srst) begin
            state_d = '0;
        end else begin
            // flip takes the shadow value held before this cycle's write
            if (vsync && run && !gate) begin
                state_d.cur = state_q.next;
            end
            if (tgt == TGT_NEXT) begin
                state_d.next = wr_base;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_q  = state_q.cur;
    assign next_q = state_q.next;

endmodule

// File: rtl/fbc_frame_base_ctrl.sv
module fbc_frame_base_ctrl
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              vsync,
    input  logic              fifo_empty,
    output logic [BASE_W-1:0] cur_base,
    output logic              run_active,
    output logic              fifo_clr
);

    wr_tgt_e           wr_tgt;
    wr_op_e            wr_op;
    ctrl_t             wr_ctrl;
    ctrl_t             ctrl_q;
    logic              srst_q;
    logic              gate_q;
    logic [BASE_W-1:0] next_base_q;

    assign wr_ctrl.run  = reg_wdata[CTRL_RUN_BIT];
    assign wr_ctrl.mode = reg_wdata[CTRL_MODE_BIT];
    assign wr_ctrl.gate = reg_wdata[CTRL_GATE_BIT];
    assign wr_ctrl.srst = reg_wdata[CTRL_SRST_BIT];

    fbc_reg_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (ADDR_W'('h00)),
        .AUX_OFS  (ADDR_W'('h10)),
        .NEXT_OFS (ADDR_W'('h20))
    ) u_decode (
        .wr   (reg_wr),
        .addr (reg_addr),
        .tgt  (wr_tgt),
        .op   (wr_op)
    );

    fbc_run_ctrl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt        (wr_tgt),
        .op         (wr_op),
        .wr_ctrl    (wr_ctrl),
        .wr_fclr    (reg_wdata[AUX_FCLR_BIT]),
        .fifo_empty (fifo_empty),
        .ctrl_q     (ctrl_q),
        .fclr_q     (fifo_clr)
    );

    assign srst_q     = ctrl_q.srst;
    assign gate_q     = ctrl_q.gate;
    assign run_active = ctrl_q.run;

    fbc_base_shadow #(
        .BASE_W (BASE_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt     (wr_tgt),
        .wr_base (reg_wdata[BASE_W-1:0]),
        .vsync   (vsync),
        .run     (ctrl_q.run),
        .gate    (ctrl_q.gate),
        .srst    (ctrl_q.srst),
        .cur_q   (cur_base),
        .next_q  (next_base_q)
    );

endmodule

// File: rtl/fbc_frame_base_ctrl_chk.sv
module fbc_frame_base_ctrl_chk #(
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              vsync,
    input logic              fifo_empty,
    input logic [BASE_W-1:0] cur_base,
    input logic              run_active,
    input logic              fifo_clr,
    input logic              srst_q,
    input logic              gate_q,
    input logic [BASE_W-1:0] next_base_q
);

    AST_FLIP_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && run_active && !gate_q && !srst_q) |=> (cur_base == $past(next_base_q))); // R2

    AST_CUR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && !srst_q) |=> $stable(cur_base)); // R10

    AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !fifo_empty && !reg_wr) |=> run_active); // R5

    AST_RUN_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_active) |-> $past(reg_wr)); // R4

    AST_FLUSH_WHILE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> ($past(reg_wr) && !$past(run_active))); // R7

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (cur_base == '0 && !run_active)); // R9

endmodule

bind fbc_frame_base_ctrl fbc_frame_base_ctrl_chk #(.BASE_W(BASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .vsync       (vsync),
    .fifo_empty  (fifo_empty),
    .cur_base    (cur_base),
    .run_active  (run_active),
    .fifo_clr    (fifo_clr),
    .srst_q      (srst_q),
    .gate_q      (gate_q),
    .next_base_q (next_base_q)
);

// File: tb/fbc_frame_base_ctrl_bench.sv
module fbc_frame_base_ctrl_bench;

    localparam int ADDR_W = 8;
    localparam int BASE_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              vsync = 1'b0;
    logic              fifo_empty = 1'b0;
    logic [BASE_W-1:0] cur_base;
    logic              run_active;
    logic              fifo_clr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fbc_frame_base_ctrl #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_fbc_frame_base_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .vsync      (vsync),
        .fifo_empty (fifo_empty),
        .cur_base   (cur_base),
        .run_active (run_active),
        .fifo_clr   (fifo_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic t_reset();
        check("R1 cur_base", cur_base, 32'h0);
        check("R1 run_active", {31'b0, run_active}, 32'h0);
        check("R1 fifo_clr", {31'b0, fifo_clr}, 32'h0);
    endtask

    task automatic t_start_and_flip();
        wr(8'h20, 32'hA000_0000);
        strobe();
        check("R2 no flip while stopped", cur_base, 32'h0);
        wr(8'h04, 32'h0000_0011);
        check("R4 run via set alias", {31'b0, run_active}, 32'h1);
        strobe();
        check("R2 flip on strobe", cur_base, 32'hA000_0000);
    endtask

    task automatic t_shadow_order();
        wr(8'h20, 32'hB000_0000);
        wr(8'h20, 32'hC000_0000);
        strobe();
        check("R3 last write wins", cur_base, 32'hC000_0000);
        wr(8'h20, 32'hE000_0000);
        @(negedge clk);
        vsync = 1'b1; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'hF000_0000;
        @(negedge clk);
        vsync = 1'b0; reg_wr = 1'b0;
        check("R3 collision promotes older", cur_base, 32'hE000_0000);
        strobe();
        check("R3 collision value next strobe", cur_base, 32'hF000_0000);
    endtask

    task automatic t_cur_readonly();
        wr(8'h30, 32'h1234_5678);
        idle(1);
        check("R10 write to 0x30 ignored", cur_base, 32'hF000_0000);
    endtask

    task automatic t_drain();
        wr(8'h10, 32'h1);
        check("R7 flush ignored while running", {31'b0, fifo_clr}, 32'h0);
        fifo_empty = 1'b0;
        wr(8'h08, 32'h0000_0010);
        check("R5 run held after mode off", {31'b0, run_active}, 32'h1);
        idle(3);
        check("R5 run held while FIFO busy", {31'b0, run_active}, 32'h1);
        fifo_empty = 1'b1;
        @(negedge clk);
        check("R5 run drops after empty", {31'b0, run_active}, 32'h0);
    endtask

    task automatic t_flush();
        wr(8'h10, 32'h1);
        check("R7 flush via plain write", {31'b0, fifo_clr}, 32'h1);
        @(negedge clk);
        check("R7 flush lasts one cycle", {31'b0, fifo_clr}, 32'h0);
        wr(8'h18, 32'h1);
        check("R7 clear alias never flushes", {31'b0, fifo_clr}, 32'h0);
        wr(8'h14, 32'h1);
        check("R7 flush via set alias", {31'b0, fifo_clr}, 32'h1);
    endtask

    task automatic t_forced_stop();
        fifo_empty = 1'b0;
        wr(8'h00, 32'h0000_0011);
        check("R4 run via plain write", {31'b0, run_active}, 32'h1);
        wr(8'h08, 32'h1);
        check("R6 forced stop", {31'b0, run_active}, 32'h0);
    endtask

    task automatic t_gate();
        fifo_empty = 1'b0;
        wr(8'h04, 32'h0000_0011);
        wr(8'h20, 32'h7700_0000);
        wr(8'h04, 32'h4000_0000);
        strobe();
        check("R8 no flip while gated", cur_base, 32'hF000_0000);
        fifo_empty = 1'b1;
        wr(8'h08, 32'h0000_0010);
        idle(2);
        check("R8 drain held while gated", {31'b0, run_active}, 32'h1);
        wr(8'h08, 32'h4000_0000);
        check("R8 drain one edge after ungate", {31'b0, run_active}, 32'h1);
        @(negedge clk);
        check("R8 drain completes", {31'b0, run_active}, 32'h0);
    endtask

    task automatic t_soft_reset();
        wr(8'h04, 32'h0000_0011);
        wr(8'h04, 32'h8000_0000);
        check("R9 run forced clear", {31'b0, run_active}, 32'h0);
        @(negedge clk);
        check("R9 current base cleared", cur_base, 32'h0);
        wr(8'h20, 32'h5500_0000);
        wr(8'h08, 32'h8000_0000);
        wr(8'h04, 32'h0000_0011);
        strobe();
        check("R9 shadow write ignored", cur_base, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_start_and_flip();
        t_shadow_order();
        t_cur_readonly();
        t_drain();
        t_flush();
        t_forced_stop();
        t_gate();
        t_soft_reset();
        idle(2);
        finish_run();
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule